// File: doc/BRIEF.md
# Telecommand BCH(63,56) Codeblock Encoder

This block turns a serial stream of uplink command bits into 64-bit codeblocks. Each codeblock carries 56 information bits. They are passed to the output unchanged, most significant bit first, and in the same cycle they are folded into a 7-stage division register. Once the 56th bit has been accepted, the block sends the complement of the 7-bit remainder and then a single zero filler bit. A receiver can then find and repair any single bit error in the first 63 bits.

Both edges use a valid/ready handshake. While information bits flow, the encoder is transparent: a bit moves from input to output in the cycle where `in_valid` and `out_ready` are both high. While the eight trailing bits are sent, the input is held off and the encoder drives the output on its own. The controller has three states. `ST_INFO` is both the idle state and the data state. `ST_PARITY` sends the parity bits and `ST_FILL` sends the filler bit. `ST_INFO` moves to `ST_PARITY` when the 56th bit transfers. `ST_PARITY` moves to `ST_FILL` when the seventh parity bit transfers. `ST_FILL` returns to `ST_INFO` when the filler bit transfers. There are no other transitions.

Top module: `bch_tc_encoder`

## Requirements
- R1: Each codeblock is 64 output transfers long. Transfers 0..55 are the accepted information bits, unchanged and in order of arrival, so the first one is the most significant.
- R2: Transfers 56..62 carry the bitwise complement of the remainder of (information polynomial · x^7) divided by g(x) = x^7 + x^6 + x^2 + 1. The highest-degree coefficient (register stage 6) goes first and stage 0 goes last. All-zero information therefore gives seven ones.
- R3: Transfer 63 is a filler bit of value 0. `block_done` is high exactly in the cycle where this filler bit transfers and is low at all other times.
- R4: In `ST_INFO`, `in_ready` equals `out_ready`, `out_valid` equals `in_valid`, and `out_bit` equals `in_bit`.
- R5: In `ST_PARITY` and `ST_FILL`, `in_ready` is 0 and `out_valid` is 1.
- R6: While a trailing bit is offered and `out_ready` is 0, the same bit stays on `out_bit` in the next cycle, and it is not skipped.
- R7: The division register starts from zero in every codeblock, so each block's parity depends only on that block's 56 information bits, whatever the blocks before it held.
- R8: A synchronous active-low `rst_n` returns the encoder to `ST_INFO`, clears the bit counter and clears the remainder. A block that was cut off is abandoned, and the next accepted bit is information bit 0 of a new block.
- R9: For any produced codeblock, the receiver syndrome is zero. The syndrome is the remainder of the 56 received information bits, XOR the 7 received parity bits (stage k at transfer 62−k), XOR 7'h7F. If the first information bit is flipped the syndrome is 98, if the last is flipped it is 69, and if parity stage k is flipped it is 2^k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An information bit is offered |
| in_bit | input | 1 | Offered information bit |
| in_ready | output | 1 | The encoder takes the offered bit this cycle |
| out_valid | output | 1 | A codeblock bit is offered |
| out_bit | output | 1 | Offered codeblock bit |
| out_ready | input | 1 | Downstream takes the offered bit this cycle |
| block_done | output | 1 | The filler bit, which is the last bit of a codeblock, transfers this cycle |

## Verification
The bench stalls the output during the parity and filler bits. An encoder that moved its parity index without a transfer would drop or repeat a parity bit, and the parity comparison would catch it. Consecutive blocks of different content check that the remainder is cleared at each block boundary, because a stale remainder would corrupt every parity after the first block. A reset part way through a block checks that the counter restarts: a counter that kept its value would frame every later block at the wrong offset. Directed all-zero, all-one and single-one blocks, together with syndrome checks of flipped bits, catch a wrong polynomial tap, a missing complement, or parity sent in reversed order.

// File: rtl/bch_tc_pkg.sv
package bch_tc_pkg;
    typedef enum logic [1:0] {
        ST_INFO   = 2'd0,
        ST_PARITY = 2'd1,
        ST_FILL   = 2'd2
    } enc_state_e;
endpackage

// File: rtl/bch_tc_lfsr.sv
module bch_tc_lfsr #(
    parameter int             DEG  = 7,
    parameter logic [DEG-1:0] POLY = 7'h45
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           shift,
    input  logic           din,
    output logic [DEG-1:0] rem
);
    logic           fb;
    logic [DEG-1:0] rem_nx;

    assign fb = rem[DEG-1] ^ din;

    // stage 0 takes the feedback; each later stage takes its neighbour, plus feedback on a tap
    assign rem_nx[0] = POLY[0] & fb;
    for (genvar i = 1; i < DEG; i++) begin : g_stage
        assign rem_nx[i] = rem[i-1] ^ (POLY[i] & fb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem <= '0;
        end else if (shift) begin
            rem <= rem_nx;
        end
    end
endmodule

// File: rtl/bch_tc_bitcnt.sv
module bch_tc_bitcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bch_tc_encoder.sv
module bch_tc_encoder
    import bch_tc_pkg::*;
#(
    parameter int                  INFO_BITS = 56,
    parameter int                  PAR_BITS  = 7,
    parameter logic [PAR_BITS-1:0] POLY      = 7'h45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    input  logic out_ready,
    output logic block_done
);
    localparam int MAX_CNT = (INFO_BITS > PAR_BITS) ? INFO_BITS : PAR_BITS;
    localparam int CNT_W   = $clog2(MAX_CNT);
    localparam logic [CNT_W-1:0] INFO_LAST = CNT_W'(INFO_BITS - 1);
    localparam logic [CNT_W-1:0] PAR_LAST  = CNT_W'(PAR_BITS - 1);

    enc_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [PAR_BITS-1:0] rem_q;
    logic                in_fire, out_fire, phase_end, par_bit;

    assign in_fire  = (state_q == ST_INFO) && in_valid && out_ready;
    assign out_fire = out_valid && out_ready;

    always_comb begin
        phase_end = 1'b0;
        unique case (state_q)
            ST_INFO:   phase_end = in_fire && (cnt_q == INFO_LAST);
            ST_PARITY: phase_end = out_ready && (cnt_q == PAR_LAST);
            ST_FILL:   phase_end = out_ready;
            default:   phase_end = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INFO:   if (phase_end) state_d = ST_PARITY;
            ST_PARITY: if (phase_end) state_d = ST_FILL;
            ST_FILL:   if (phase_end) state_d = ST_INFO;
            default:   state_d = ST_INFO;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INFO;
        end else begin
            state_q <= state_d;
        end
    end

    bch_tc_bitcnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_end),
        .inc   (out_fire && !phase_end),
        .cnt   (cnt_q)
    );

    bch_tc_lfsr #(.DEG(PAR_BITS), .POLY(POLY)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q == ST_FILL) && out_ready),
        .shift (in_fire),
        .din   (in_bit),
        .rem   (rem_q)
    );

    // parity selection: highest stage first, complemented
    always_comb begin
        par_bit = 1'b0;
        for (int k = 0; k < PAR_BITS; k++) begin
            if (cnt_q == CNT_W'(PAR_BITS - 1 - k)) par_bit = ~rem_q[k];
        end
    end

    // output logic
    always_comb begin
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        out_bit    = 1'b0;
        block_done = 1'b0;
        unique case (state_q)
            ST_INFO: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_bit   = in_bit;
            end
            ST_PARITY: begin
                out_valid = 1'b1;
                out_bit   = par_bit;
            end
            ST_FILL: begin
                out_valid  = 1'b1;
                out_bit    = 1'b0;
                block_done = out_ready;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bch_tc_encoder_chk.sv
module bch_tc_encoder_chk
    import bch_tc_pkg::*;
#(
    parameter int INFO_BITS = 56,
    parameter int CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_bit,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_bit,
    input logic             out_ready,
    input logic             block_done,
    input enc_state_e       state,
    input logic [CNT_W-1:0] cnt
);
    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INFO) |-> (in_ready == out_ready && out_valid == in_valid && out_bit == in_bit));

    assert_tail_no_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INFO) |-> (!in_ready && out_valid));

    assert_tail_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_INFO && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(state)));

    assert_done_on_filler_R3: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> (out_valid && out_ready && !out_bit && state == ST_FILL));

    assert_done_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> (!block_done && state == ST_INFO && cnt == '0));

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INFO) |-> (int'(cnt) < INFO_BITS));

    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |=> (state == ST_INFO && cnt == '0));
endmodule

bind bch_tc_encoder bch_tc_encoder_chk #(
    .INFO_BITS (INFO_BITS),
    .CNT_W     (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_bit     (in_bit),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .out_ready  (out_ready),
    .block_done (block_done),
    .state      (state_q),
    .cnt        (cnt_q)
);

// File: tb/bch_tc_encoder_tb_top.sv
`timescale 1ns/1ps
module bch_tc_encoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, out_bit, block_done;

    always #2 clk = ~clk;

    bch_tc_encoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bit     (in_bit),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_bit    (out_bit),
        .out_ready  (out_ready),
        .block_done (block_done)
    );

    int checks = 0;
    int errors = 0;
    int p_in = 100;
    int p_out = 100;
    int pos = 0;
    int cyc = 0;
    bit src_q[$];
    bit sent_q[$];
    bit fired = 0;
    bit hold_v = 0;
    bit hold_b = 0;
    bit syn_done = 0;
    logic [63:0] blk = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] rem_of(input logic [55:0] d);
        logic [6:0] r = '0;
        logic fb;
        for (int i = 55; i >= 0; i--) begin
            fb = r[6] ^ d[i];
            r = {r[5] ^ fb, r[4], r[3], r[2], r[1] ^ fb, r[0], fb};
        end
        return r;
    endfunction

    function automatic logic [6:0] syndrome(input logic [63:0] b);
        return rem_of(b[63:8]) ^ b[7:1] ^ 7'h7F;
    endfunction

    task automatic check_block();
        logic [55:0] info;
        logic [6:0]  expp;
        info = '0;
        if (sent_q.size() < 56) begin
            chk(1'b0, "R1", "accepted bits per block", sent_q.size(), 56);
            sent_q.delete();
            return;
        end
        for (int i = 55; i >= 0; i--) info[i] = sent_q.pop_front();
        expp = ~rem_of(info);
        chk(blk[63:8] == info, "R1", "info bits", int'(blk[39:8]), int'(info[31:0]));
        chk(blk[7:1] == expp, "R2", "parity (R7 fresh remainder)", int'(blk[7:1]), int'(expp));
        chk(blk[0] == 1'b0, "R3", "filler bit", int'(blk[0]), 0);
        chk(syndrome(blk) == 7'd0, "R9", "clean syndrome", int'(syndrome(blk)), 0);
        if (!syn_done) begin
            syn_done = 1;
            chk(syndrome(blk ^ (64'd1 << 63)) == 7'd98, "R9", "first info flip",
                int'(syndrome(blk ^ (64'd1 << 63))), 98);
            chk(syndrome(blk ^ (64'd1 << 8)) == 7'd69, "R9", "last info flip",
                int'(syndrome(blk ^ (64'd1 << 8))), 69);
            for (int k = 0; k < 7; k++) begin
                chk(syndrome(blk ^ (64'd1 << (1 + k))) == 7'(1 << k), "R9", "parity flip",
                    int'(syndrome(blk ^ (64'd1 << (1 + k)))), 1 << k);
            end
        end
    endtask

    // stimulus: changes 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (!rst_n) begin
            in_valid = 1'b0;
        end else begin
            if (fired) in_valid = 1'b0;
            if (!in_valid && src_q.size() > 0 && int'($urandom % 100) < p_in) begin
                in_bit   = src_q.pop_front();
                in_valid = 1'b1;
            end
        end
        out_ready = int'($urandom % 100) < p_out;
    end

    // monitor: samples at the falling edge
    always @(negedge clk) begin
        fired = 0;
        if (!rst_n) begin
            pos = 0;
            sent_q.delete();
            hold_v = 0;
        end else begin
            if (hold_v) begin
                chk(out_valid && out_bit == hold_b, "R6", "stalled bit held", int'(out_bit), int'(hold_b));
                hold_v = 0;
            end
            if (pos < 56) begin
                chk(in_ready == out_ready && out_valid == in_valid, "R4", "handshake pass-through",
                    int'({in_ready, out_valid}), int'({out_ready, in_valid}));
                if (in_valid) chk(out_bit == in_bit, "R4", "data pass-through", int'(out_bit), int'(in_bit));
            end else begin
                chk(!in_ready && out_valid, "R5", "tail ready/valid", int'({in_ready, out_valid}), 1);
                if (!out_ready) begin
                    hold_v = 1;
                    hold_b = out_bit;
                end
            end
            chk(block_done == (out_valid && out_ready && pos == 63), "R3", "block_done",
                int'(block_done), int'(out_valid && out_ready && pos == 63));
            if (in_valid && in_ready) begin
                fired = 1;
                sent_q.push_back(in_bit);
            end
            if (out_valid && out_ready) begin
                blk[63 - pos] = out_bit;
                pos++;
                if (pos == 64) begin
                    check_block();
                    pos = 0;
                end
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            summary();
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        wait (src_q.size() == 0 && sent_q.size() == 0 && pos == 0 && !in_valid);
        repeat (2) @(negedge clk);
    endtask

    task automatic push_block(input logic [55:0] d);
        for (int i = 55; i >= 0; i--) src_q.push_back(d[i]);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #0.5;
        rst_n = 1'b0;
        p_out = 100;
        src_q.delete();
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle after reset, transparent handshake, nothing offered
        chk(in_ready == 1'b1 && out_valid == 1'b0 && block_done == 1'b0, "R8", "state after reset",
            int'({in_ready, out_valid, block_done}), 4);
    endtask

    initial begin
        void'($urandom(32'h1D2C3B4A));
        do_reset();

        p_in = 100; p_out = 100;
        push_block(56'd0);
        wait_idle();
        chk(blk[7:1] == 7'h7F, "R2", "all-zero parity", int'(blk[7:1]), 127);

        push_block({56{1'b1}});
        wait_idle();
        push_block({1'b1, 55'd0});
        wait_idle();
        push_block(56'd1);
        wait_idle();

        // R7: blocks of random content at varied flow rates
        for (int b = 0; b < 24; b++) begin
            p_in  = (b % 3 == 0) ? 100 : ((b % 3 == 1) ? 70 : 35);
            p_out = (b % 4 == 0) ? 100 : ((b % 4 == 1) ? 30 : 65);
            push_block({$urandom, $urandom}[55:0]);
            wait_idle();
        end

        // R8: reset in the middle of a block, then framing must restart
        p_in = 100; p_out = 100;
        push_block({$urandom, $urandom}[55:0]);
        wait (pos == 20);
        do_reset();
        for (int b = 0; b < 3; b++) begin
            p_in = 80; p_out = 60;
            push_block({$urandom, $urandom}[55:0]);
            wait_idle();
        end

        summary();
        $finish;
    end
endmodule